// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a small microcontroller datapath. Given an operation code, two operands and the carry bit held in its own status register, it produces the result and a candidate value for each of six status flags in the same cycle, with no register on that path. It also produces a write mask that names the flags the selected operation is allowed to change. The flags are carry C, zero Z, negative N, two's-complement overflow V, signed S and half-carry H.

When `exec_i` is high, the next rising clock edge commits the masked flags into the status register. Flags outside the mask keep their old values. The carry input of the add-with-carry, subtract-with-carry and rotate operations is always taken from that register. Operand fetch, write-back and instruction decode are the job of the surrounding core.

In this project the status vector is laid out as bit0=C, bit1=Z, bit2=N, bit3=V, bit4=S, bit5=H. The layout applies to `flags_o`, `fmask_o` and `status_o`.

Top module: `alu8_flagged`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) return a+b or a+b+C. They write all six flags: C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R2: Codes 2 (subtract) and 3 (subtract with carry) return a-b or a-b-C. They write all six flags: C is the borrow out of bit 7, H is the borrow into bit 4, and V is signed overflow.
- R3: Codes 4 (AND), 5 (OR) and 6 (XOR) write only Z, N, V and S, with V forced to 0. C and H in the status register are left unchanged.
- R4: Codes 9 (increment) and 10 (decrement) write only Z, N, V and S. V is 1 only for the step 0x7F to 0x80 (increment) or 0x80 to 0x7F (decrement).
- R5: Code 7 (one's complement) returns 0xFF-a, sets C to 1 and V to 0, and writes every flag except H. Code 8 (negate) returns 0x00-a and writes all six flags, with C=1 whenever a is not zero.
- R6: Code 11 shifts left and fills bit 0 with 0. Code 12 shifts right and fills bit 7 with 0. Code 15 shifts right and keeps bit 7. Each of them moves the bit that is shifted out into C and writes every flag except H.
- R7: Code 13 rotates left, with the stored C entering bit 0 and bit 7 leaving into C. Code 14 rotates right, with the stored C entering bit 7 and bit 0 leaving into C. Shifts and rotates set V to N xor the new C.
- R8: Code 16 exchanges the two 4-bit halves of a and writes no flag.
- R9: Whenever N or V is written, S is written as N xor V. Z is 1 exactly when the 8-bit result is zero. N equals result bit 7.
- R10: Reset clears the status register to 0. At a rising edge with `exec_i` high, masked flags take their new values and all other flags keep theirs. With `exec_i` low, the status register does not change.
- R11: Codes 17 to 31 pass a through to the result and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| exec_i | input | 1 | Commit masked flags at the next rising edge |
| res_o | output | DATA_W | Result (combinational) |
| flags_o | output | 6 | Candidate flag values (combinational) |
| fmask_o | output | 6 | Flags the operation may write (combinational) |
| status_o | output | 6 | Status register |

## Verification
The result, candidate flags and mask settle in the cycle in which the inputs are applied. The bench drives the inputs at the falling edge and compares these outputs 1 ns later, before any rising edge. The status register changes one edge later, so its expected value is checked at the next falling edge, just before the following vector is driven. That check compares the register against a model that merges the previous vector's masked flags. Before each carry-dependent vector, the bench applies a preset operation that sets the stored C to a known 0 or 1, and every operand value is swept under both carry values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W   = 5;
   localparam int FLAG_W = 6;

   localparam int FC = 0;
   localparam int FZ = 1;
   localparam int FN = 2;
   localparam int FV = 3;
   localparam int FS = 4;
   localparam int FH = 5;

   localparam logic [FLAG_W-1:0] MASK_ALL   = 6'h3F;
   localparam logic [FLAG_W-1:0] MASK_NOH   = 6'h1F;
   localparam logic [FLAG_W-1:0] MASK_LOGIC = 6'h1E;
   localparam logic [FLAG_W-1:0] MASK_NONE  = 6'h00;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_COM  = 5'd7,
      OP_NEG  = 5'd8,
      OP_INC  = 5'd9,
      OP_DEC  = 5'd10,
      OP_LSL  = 5'd11,
      OP_LSR  = 5'd12,
      OP_ROL  = 5'd13,
      OP_ROR  = 5'd14,
      OP_ASR  = 5'd15,
      OP_SWAP = 5'd16
   } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
   parameter int W     = 8,
   parameter bit SPLIT = 1'b1
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         half_o,
   output logic         ovf_o
);
   localparam int HW = W / 2;

   logic [W-1:0] yy;
   logic         ci;
   logic         c_raw;
   logic         h_raw;

   assign yy = sub_i ? ~y_i : y_i;
   assign ci = sub_i ? ~cin_i : cin_i;

   generate
      if (SPLIT) begin : g_split
         logic [HW:0]   lo;
         logic [W-HW:0] hi;
         assign lo    = {1'b0, x_i[HW-1:0]} + {1'b0, yy[HW-1:0]} + {{HW{1'b0}}, ci};
         assign hi    = {1'b0, x_i[W-1:HW]} + {1'b0, yy[W-1:HW]} + {{(W-HW){1'b0}}, lo[HW]};
         assign sum_o = {hi[W-HW-1:0], lo[HW-1:0]};
         assign c_raw = hi[W-HW];
         assign h_raw = lo[HW];
      end else begin : g_flat
         logic [W:0] full;
         logic [W-1:0] mix;
         assign full  = {1'b0, x_i} + {1'b0, yy} + {{W{1'b0}}, ci};
         assign sum_o = full[W-1:0];
         assign c_raw = full[W];
         assign mix   = x_i ^ yy ^ full[W-1:0];
         assign h_raw = mix[HW];
      end
   endgenerate

   assign cout_o = sub_i ? ~c_raw : c_raw;
   assign half_o = sub_i ? ~h_raw : h_raw;
   assign ovf_o  = (x_i[W-1] == yy[W-1]) && (sum_o[W-1] != x_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic [OP_W-1:0] op_i,
   output logic [W-1:0]    res_o
);
   localparam int HW = W / 2;

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_COM:  res_o = ~a_i;
         OP_SWAP: res_o = {a_i[HW-1:0], a_i[W-1:HW]};
         default: res_o = a_i;
      endcase
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]    a_i,
   input  logic            cin_i,
   input  logic [OP_W-1:0] op_i,
   output logic [W-1:0]    res_o,
   output logic            cout_o
);
   always_comb begin
      case (op_i)
         OP_LSL:  begin res_o = {a_i[W-2:0], 1'b0};     cout_o = a_i[W-1]; end
         OP_ROL:  begin res_o = {a_i[W-2:0], cin_i};    cout_o = a_i[W-1]; end
         OP_LSR:  begin res_o = {1'b0, a_i[W-1:1]};     cout_o = a_i[0];   end
         OP_ROR:  begin res_o = {cin_i, a_i[W-1:1]};    cout_o = a_i[0];   end
         OP_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]}; cout_o = a_i[0];   end
         default: begin res_o = a_i;                    cout_o = cin_i;    end
      endcase
   end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
   import alu8_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              exec_i,
   output logic [DATA_W-1:0] res_o,
   output logic [5:0]        flags_o,
   output logic [5:0]        fmask_o,
   output logic [5:0]        status_o
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu8_flagged: DATA_W must be even and at least 4");
      end
   endgenerate

   logic [DATA_W-1:0] ar_x, ar_y, ar_sum, lg_res, sh_res;
   logic              ar_cin, ar_sub, ar_c, ar_h, ar_v, sh_c;
   logic              c_in;
   logic              n_new, z_new, c_new, v_new, h_new;
   logic [DATA_W-1:0] res;
   logic [5:0]        mask;
   logic [5:0]        st_q;

   assign c_in = st_q[FC];

   // operand steering into the shared adder
   always_comb begin
      ar_x   = a_i;
      ar_y   = b_i;
      ar_cin = 1'b0;
      ar_sub = 1'b0;
      case (op_i)
         OP_ADC: ar_cin = c_in;
         OP_SUB: ar_sub = 1'b1;
         OP_SBC: begin ar_sub = 1'b1; ar_cin = c_in; end
         OP_NEG: begin ar_sub = 1'b1; ar_x = '0; ar_y = a_i; end
         OP_INC: ar_y = DATA_W'(1);
         OP_DEC: begin ar_sub = 1'b1; ar_y = DATA_W'(1); end
         default: ;
      endcase
   end

   alu_arith #(.W(DATA_W), .SPLIT(SPLIT_ADDER)) arith_i (
      .x_i(ar_x), .y_i(ar_y), .cin_i(ar_cin), .sub_i(ar_sub),
      .sum_o(ar_sum), .cout_o(ar_c), .half_o(ar_h), .ovf_o(ar_v)
   );

   alu_logic #(.W(DATA_W)) logic_i (
      .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(lg_res)
   );

   alu_shift #(.W(DATA_W)) shift_i (
      .a_i(a_i), .cin_i(c_in), .op_i(op_i), .res_o(sh_res), .cout_o(sh_c)
   );

   // result and flag selection
   always_comb begin
      res   = a_i;
      c_new = c_in;
      h_new = st_q[FH];
      v_new = 1'b0;
      mask  = MASK_NONE;
      case (op_i)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            res = ar_sum; c_new = ar_c; h_new = ar_h; v_new = ar_v; mask = MASK_ALL;
         end
         OP_INC, OP_DEC: begin
            res = ar_sum; v_new = ar_v; mask = MASK_LOGIC;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res = lg_res; mask = MASK_LOGIC;
         end
         OP_COM: begin
            res = lg_res; c_new = 1'b1; mask = MASK_NOH;
         end
         OP_SWAP: res = lg_res;
         OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
            res = sh_res; c_new = sh_c; v_new = sh_res[MSB] ^ sh_c; mask = MASK_NOH;
         end
         default: ;
      endcase
   end

   assign n_new = res[MSB];
   assign z_new = (res == '0);

   assign res_o   = res;
   assign flags_o = {h_new, n_new ^ v_new, v_new, n_new, z_new, c_new};
   assign fmask_o = mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= '0;
      else if (exec_i) st_q <= (st_q & ~mask) | (flags_o & mask);
   end

   assign status_o = st_q;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        op_i,
   input logic              exec_i,
   input logic [DATA_W-1:0] res_o,
   input logic [5:0]        flags_o,
   input logic [5:0]        fmask_o,
   input logic [5:0]        status_o
);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> status_o == $past(status_o));

   assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i |=> status_o == (($past(status_o) & ~$past(fmask_o)) | ($past(flags_o) & $past(fmask_o))));

   assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fmask_o[4] |-> flags_o[4] == (flags_o[2] ^ flags_o[3]));

   assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fmask_o[1] |-> flags_o[1] == (res_o == '0));

   assert_swap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 5'd16 |-> fmask_o == 6'h00);

   assert_com_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 5'd7 |-> (flags_o[0] && fmask_o[0] && !fmask_o[5]));
endmodule

bind alu8_flagged alu8_flagged_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .exec_i(exec_i), .res_o(res_o),
   .flags_o(flags_o), .fmask_o(fmask_o), .status_o(status_o)
);

// File: tb/alu8_flagged_tb_top.sv
`timescale 1ns/1ps
module alu8_flagged_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] a_i = '0;
   logic [7:0] b_i = '0;
   logic       exec_i = 1'b0;
   logic [7:0] res_o;
   logic [5:0] flags_o, fmask_o, status_o;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;
   logic [5:0] st_m = '0;

   always #2.5 clk = ~clk;

   alu8_flagged dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .exec_i(exec_i), .res_o(res_o), .flags_o(flags_o),
      .fmask_o(fmask_o), .status_o(status_o)
   );

   function automatic string req_of(input int op);
      case (op)
         0, 1:   return "R1";
         2, 3:   return "R2";
         4, 5, 6: return "R3";
         7, 8:   return "R5";
         9, 10:  return "R4";
         11, 12, 15: return "R6";
         13, 14: return "R7";
         16:     return "R8";
         default: return "R11";
      endcase
   endfunction

   function automatic int sgn(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic int bval(input int i);
      case (i)
         0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
         4: return 8'h10;  5: return 8'h55;  6: return 8'h7F;  7: return 8'h80;
         8: return 8'h81;  9: return 8'hAA;  10: return 8'hF0; 11: return 8'hFE;
         12: return 8'hFF; 13: return 8'h08; 14: return 8'h37; default: return 8'hC9;
      endcase
   endfunction

   task automatic model(input int op, input int a, input int b, input int c,
                        output logic [7:0] r, output logic [5:0] f, output logic [5:0] m);
      int t, sr, cc, x, y;
      logic cf, hf, vf, nf;
      cf = c[0]; hf = st_m[5]; vf = 1'b0; m = 6'h00; r = 8'(a);
      case (op)
         0, 1: begin
            cc = (op == 1) ? c : 0;
            t = a + b + cc; r = 8'(t); cf = (t > 255);
            hf = ((a % 16) + (b % 16) + cc) > 15;
            sr = sgn(a) + sgn(b) + cc; vf = (sr > 127) || (sr < -128); m = 6'h3F;
         end
         2, 3, 8: begin
            cc = (op == 3) ? c : 0;
            x = (op == 8) ? 0 : a; y = (op == 8) ? a : b;
            t = x - y - cc; r = 8'(t); cf = (t < 0);
            hf = ((x % 16) - (y % 16) - cc) < 0;
            sr = sgn(x) - sgn(y) - cc; vf = (sr > 127) || (sr < -128); m = 6'h3F;
         end
         4: begin r = 8'(a & b); m = 6'h1E; end
         5: begin r = 8'(a | b); m = 6'h1E; end
         6: begin r = 8'(a ^ b); m = 6'h1E; end
         7: begin r = 8'(255 - a); cf = 1'b1; m = 6'h1F; end
         9: begin r = 8'(a + 1); vf = (a == 127); m = 6'h1E; end
         10: begin r = 8'(a - 1); vf = (a == 128); m = 6'h1E; end
         11: begin r = 8'(a * 2); cf = (a >= 128); end
         12: begin r = 8'(a / 2); cf = (a % 2) != 0; end
         13: begin r = 8'((a * 2) % 256 + c); cf = (a >= 128); end
         14: begin r = 8'(a / 2 + c * 128); cf = (a % 2) != 0; end
         15: begin r = 8'(a / 2 + (a / 128) * 128); cf = (a % 2) != 0; end
         16: r = 8'((a % 16) * 16 + a / 16);
         default: ;
      endcase
      if (op >= 11 && op <= 15) begin
         vf = r[7] ^ cf; m = 6'h1F;
      end
      nf = r[7];
      f = {hf, nf ^ vf, vf, nf, (r == 8'h00), cf};
   endtask

   task automatic apply(input int op, input int a, input int b, input bit ex);
      logic [7:0] er;
      logic [5:0] ef, em;
      @(negedge clk);
      n_vec++;
      if (status_o !== st_m) begin
         n_bad++;
         $display("FAIL R10 status before op %0d: got %h expected %h", op, status_o, st_m);
      end
      op_i = 5'(op); a_i = 8'(a); b_i = 8'(b); exec_i = ex;
      #1;
      model(op, a, b, int'(st_m[0]), er, ef, em);
      n_vec++;
      if (res_o !== er || fmask_o !== em || (flags_o & em) !== (ef & em)) begin
         n_bad++;
         $display("FAIL %s op %0d a=%h b=%h c=%0d: got res %h flags %h mask %h expected res %h flags %h mask %h",
                  req_of(op), op, a, b, st_m[0], res_o, flags_o & fmask_o, fmask_o, er, ef & em, em);
      end
      @(posedge clk);
      if (ex) st_m = (st_m & ~em) | (ef & em);
   endtask

   // stored carry preset: shift-right of zero clears C, complement sets it
   task automatic preset(input int c);
      if (c != 0) apply(7, 0, 0, 1'b1);
      else        apply(12, 0, 0, 1'b1);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_vec++;
      if (status_o !== 6'h00) begin
         n_bad++;
         $display("FAIL R10 reset status: got %h expected 00", status_o);
      end
      rst_n = 1'b1;

      // R1 R2: add/sub families under both stored carry values
      for (int op = 0; op <= 3; op++)
         for (int c = 0; c <= 1; c++)
            for (int bi = 0; bi < 16; bi++)
               for (int a = 0; a < 256; a++) begin
                  preset(c);
                  apply(op, a, bval(bi), 1'b1);
               end

      // R3: bitwise ops leave C and H alone (status compared next vector)
      for (int op = 4; op <= 6; op++)
         for (int bi = 0; bi < 16; bi++)
            for (int a = 0; a < 256; a++)
               apply(op, a, bval(bi), 1'b1);

      // R4 R5 R6 R7 R8: single-operand ops, both carry values
      for (int op = 7; op <= 16; op++)
         for (int c = 0; c <= 1; c++)
            for (int a = 0; a < 256; a++) begin
               if (op < 11 || op > 15) begin
                  // set H via add 0x0F+0x01 so untouched H is visible
                  apply(0, 8'h0F, 8'h01, 1'b1);
               end
               preset(c);
               apply(op, a, 8'h5A, 1'b1);
            end

      // R11: unused codes pass a and write nothing
      for (int op = 17; op < 32; op++)
         for (int a = 0; a < 256; a += 17)
            apply(op, a, 255 - a, 1'b1);

      // R10: exec low leaves the status register as it was
      apply(7, 8'h00, 8'h00, 1'b1);
      for (int a = 0; a < 256; a += 5)
         apply(12, a, 0, 1'b0);
      apply(0, 8'h00, 8'h00, 1'b0);

      @(negedge clk);
      n_vec++;
      if (status_o !== st_m) begin
         n_bad++;
         $display("FAIL R10 final status: got %h expected %h", status_o, st_m);
      end
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got no completion expected completion");
         summary();
      end
   end
endmodule